// File: doc/BRIEF.md
# Byte-Wide Command Window

This block decodes a small I/O window in which every access must be exactly one byte wide. Through it, guest software can set or clear a ROM write-protect flag, request removal of emulated disk controllers and network adapters, and feed characters into a shared text log. The same flag can also be written from a second, fixed-address port, so the flag register sits here and accepts writes from both routes.

Requests leave the block as single-cycle pulses on the cycle after the write: a disk-removal pulse, a network-removal pulse and a log strobe with its character. A command register at one offset either decodes the value as a removal request or, for any other value, passes it on as a log character. A second offset carries a single command that removes both disks and network adapters together. Reads return the flag at its own offset and all ones everywhere else.

Top module: `bar_cmd_window`

## Requirements
- R1: After reset the ROM lock flag reads 0 and the disk pulse, network pulse and log strobe are low.
- R2: A byte read (size code 0) at offset 0x00 returns the flag in bit 0 with bits 7:1 zero, in the same cycle; a read at any other offset, or a read with size code 1 (16-bit), 2 (32-bit) or 3, returns 0xFF.
- R3: A byte write at offset 0x00 sets the ROM lock flag to bit 0 of the written value, visible from the next cycle; bits 7:1 are discarded.
- R4: A byte write of 0x01 at offset 0x04 raises both the disk pulse and the network pulse in the next cycle; any other value written there has no effect.
- R5: At offset 0x08 a byte write of 0x01 raises only the disk pulse and 0x02 only the network pulse, in the next cycle; any other value raises the log strobe in the next cycle with that value on the log byte output.
- R6: Writes at offsets other than 0x00, 0x04 and 0x08, and writes with a size code other than 0, change neither the flag nor any pulse or strobe.
- R7: A write from the fixed port sets the flag to bit 0 of its data in the next cycle; when it coincides with a window write at offset 0x00, the fixed port's value is taken.
- R8: The auxiliary-only marker that accompanies disk requests stays low at all times.
- R9: Every pulse and the log strobe last exactly one cycle per triggering write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bar_wr | input | 1 | Window write strobe |
| bar_rd | input | 1 | Window read strobe |
| bar_addr | input | 8 | Byte offset within the window |
| bar_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 reserved |
| bar_wdata | input | 8 | Write data |
| bar_rdata | output | 8 | Read data, combinational |
| fix_wr | input | 1 | Flag write from the fixed port |
| fix_wdata | input | 8 | Fixed port flag data (bit 0 used) |
| rom_lock | output | 1 | ROM write-protect flag |
| unplug_disk | output | 1 | Disk removal pulse |
| unplug_disk_aux | output | 1 | Auxiliary-only marker for disk removal |
| unplug_nic | output | 1 | Network adapter removal pulse |
| log_valid | output | 1 | Log character strobe |
| log_byte | output | 8 | Log character |

## Verification
The flag register has two writers, the fixed port and the window's offset 0x00, and both can land in the same cycle. The bench provokes this with directed collisions that carry opposite bit-0 values, then with a random stream where both strobes fire independently, and judges the next-cycle flag against a reference model in which the fixed port always wins. The model also tracks the one-cycle pulses, so a collision that wrongly lets a window command slip through, or a stretched pulse, shows up on the same clock comparison.

// File: rtl/bar_cmd_window.sv
`timescale 1ns/1ps
module bar_cmd_window #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int OFS_FLAGS = 0,
  parameter int OFS_BOTH  = 4,
  parameter int OFS_CMD   = 8,
  parameter int CMD_DISK  = 1,
  parameter int CMD_NIC   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bar_wr,
  input  logic          bar_rd,
  input  logic [AW-1:0] bar_addr,
  input  logic [1:0]    bar_size,
  input  logic [DW-1:0] bar_wdata,
  output logic [DW-1:0] bar_rdata,
  input  logic          fix_wr,
  input  logic [DW-1:0] fix_wdata,
  output logic          rom_lock,
  output logic          unplug_disk,
  output logic          unplug_disk_aux,
  output logic          unplug_nic,
  output logic          log_valid,
  output logic [DW-1:0] log_byte
);
  localparam logic [AW-1:0] A_FLAGS = AW'(OFS_FLAGS);
  localparam logic [AW-1:0] A_BOTH  = AW'(OFS_BOTH);
  localparam logic [AW-1:0] A_CMD   = AW'(OFS_CMD);
  localparam logic [DW-1:0] V_DISK  = DW'(CMD_DISK);
  localparam logic [DW-1:0] V_NIC   = DW'(CMD_NIC);

  logic byte_acc, wr_ok, hit_flags, hit_both, hit_cmd;
  logic both_go, cmd_disk, cmd_nic, cmd_log;

  assign byte_acc  = (bar_size == 2'd0);
  assign wr_ok     = bar_wr && byte_acc;
  assign hit_flags = (bar_addr == A_FLAGS);
  assign hit_both  = (bar_addr == A_BOTH);
  assign hit_cmd   = (bar_addr == A_CMD);

  assign both_go   = wr_ok && hit_both && (bar_wdata == V_DISK);
  assign cmd_disk  = wr_ok && hit_cmd && (bar_wdata == V_DISK);
  assign cmd_nic   = wr_ok && hit_cmd && (bar_wdata == V_NIC);
  assign cmd_log   = wr_ok && hit_cmd && !cmd_disk && !cmd_nic;

  assign bar_rdata = (bar_rd && byte_acc && hit_flags) ? {{(DW-1){1'b0}}, rom_lock} : '1;
  assign unplug_disk_aux = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_lock    <= 1'b0;
      unplug_disk <= 1'b0;
      unplug_nic  <= 1'b0;
      log_valid   <= 1'b0;
      log_byte    <= '0;
    end else begin
      if (fix_wr)
        rom_lock <= fix_wdata[0];
      else if (wr_ok && hit_flags)
        rom_lock <= bar_wdata[0];
      unplug_disk <= both_go || cmd_disk;
      unplug_nic  <= both_go || cmd_nic;
      log_valid   <= cmd_log;
      if (cmd_log)
        log_byte <= bar_wdata;
    end
  end
endmodule

// File: rtl/bar_cmd_window_chk.sv
`timescale 1ns/1ps
module bar_cmd_window_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bar_wr,
  input logic          bar_rd,
  input logic [AW-1:0] bar_addr,
  input logic [1:0]    bar_size,
  input logic [DW-1:0] bar_wdata,
  input logic [DW-1:0] bar_rdata,
  input logic          fix_wr,
  input logic [DW-1:0] fix_wdata,
  input logic          rom_lock,
  input logic          unplug_disk,
  input logic          unplug_nic,
  input logic          log_valid,
  input logic [DW-1:0] log_byte
);
  // R2
  wide_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_rd && bar_size != 2'd0) |-> (bar_rdata == '1));
  // R3
  flag_from_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_wr && bar_size == 2'd0 && bar_addr == '0 && !fix_wr) |=> (rom_lock == $past(bar_wdata[0])));
  // R7
  fixed_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_wr |=> (rom_lock == $past(fix_wdata[0])));
  // R4
  combined_unplug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_wr && bar_size == 2'd0 && bar_addr == AW'(4) && bar_wdata == DW'(1)) |=> (unplug_disk && unplug_nic));
  // R5
  log_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_wr && bar_size == 2'd0 && bar_addr == AW'(8) && bar_wdata > DW'(2)) |=> (log_valid && log_byte == $past(bar_wdata)));
  // R6
  wide_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bar_wr || bar_size != 2'd0) |=> (!unplug_disk && !unplug_nic && !log_valid));
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_wr && !(bar_wr && bar_size == 2'd0 && bar_addr == '0)) |=> $stable(rom_lock));
endmodule

bind bar_cmd_window bar_cmd_window_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bar_wr(bar_wr), .bar_rd(bar_rd), .bar_addr(bar_addr),
  .bar_size(bar_size), .bar_wdata(bar_wdata), .bar_rdata(bar_rdata), .fix_wr(fix_wr),
  .fix_wdata(fix_wdata), .rom_lock(rom_lock), .unplug_disk(unplug_disk),
  .unplug_nic(unplug_nic), .log_valid(log_valid), .log_byte(log_byte)
);

// File: tb/bar_cmd_window_tb.sv
`timescale 1ns/1ps
module bar_cmd_window_tb;
  logic clk = 0, rst_n = 0;
  logic bar_wr = 0, bar_rd = 0, fix_wr = 0;
  logic [7:0] bar_addr = 0, bar_wdata = 0, fix_wdata = 0;
  logic [1:0] bar_size = 0;
  logic [7:0] bar_rdata, log_byte;
  logic rom_lock, unplug_disk, unplug_disk_aux, unplug_nic, log_valid;

  int checks = 0, failures = 0;
  bit done = 0;
  int m_lock = 0, m_disk = 0, m_nic = 0, m_log = 0, m_byte = 0;

  always #4 clk = ~clk;

  bar_cmd_window u_dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: update from the inputs held across the edge, then compare
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m_lock = 0; m_disk = 0; m_nic = 0; m_log = 0; m_byte = 0;
    end else begin
      int a, d;
      bit ok;
      a = bar_addr; d = bar_wdata; ok = bar_wr && bar_size == 0;
      if (fix_wr) m_lock = fix_wdata[0];
      else if (ok && a == 0) m_lock = d & 1;
      m_disk = ok && ((a == 4 && d == 1) || (a == 8 && d == 1));
      m_nic  = ok && ((a == 4 && d == 1) || (a == 8 && d == 2));
      m_log  = ok && a == 8 && d != 1 && d != 2;
      if (m_log) m_byte = d;
    end
    if (rst_n && !done) begin
      int er;
      er = (bar_rd && bar_size == 0 && bar_addr == 0) ? m_lock : 8'hFF;
      chk("R3/R7 rom_lock", rom_lock, m_lock);
      chk("R4/R5/R9 unplug_disk", unplug_disk, m_disk);
      chk("R4/R5/R9 unplug_nic", unplug_nic, m_nic);
      chk("R5/R6 log_valid", log_valid, m_log);
      if (m_log) chk("R5 log_byte", log_byte, m_byte);
      chk("R2 bar_rdata", bar_rdata, er);
      chk("R8 unplug_disk_aux", unplug_disk_aux, 0);
    end
  end

  task automatic op(bit w, bit r, int a, int s, int d, bit fw, int fd);
    @(negedge clk);
    bar_wr = w; bar_rd = r; bar_addr = 8'(a); bar_size = 2'(s); bar_wdata = 8'(d);
    fix_wr = fw; fix_wdata = 8'(fd);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 rom_lock", rom_lock, 0);
    chk("R1 unplug_disk", unplug_disk, 0);
    chk("R1 unplug_nic", unplug_nic, 0);
    chk("R1 log_valid", log_valid, 0);
    op(0, 1, 0, 0, 0, 0, 0);          // R2 read flag
    op(1, 0, 0, 0, 8'hFF, 0, 0);      // R3 set lock, upper bits dropped
    op(0, 1, 0, 0, 0, 0, 0);
    op(0, 1, 0, 1, 0, 0, 0);          // R2 wide read
    op(0, 1, 3, 0, 0, 0, 0);          // R2 other offset
    op(1, 0, 0, 0, 8'h02, 0, 0);      // R3 clear
    op(1, 0, 4, 0, 1, 0, 0);          // R4 combined
    op(1, 0, 4, 0, 1, 0, 0);          // R9 back to back
    op(0, 0, 0, 0, 0, 0, 0);          // R9 pulse drops
    op(1, 0, 4, 0, 2, 0, 0);          // R4 ignored value
    op(1, 0, 8, 0, 1, 0, 0);          // R5 disk
    op(1, 0, 8, 0, 2, 0, 0);          // R5 nic
    op(1, 0, 8, 0, 8'h41, 0, 0);      // R5 log
    op(1, 0, 8, 0, 8'h00, 0, 0);      // R5 log zero
    op(1, 0, 8, 2, 1, 0, 0);          // R6 wide write
    op(1, 0, 0, 1, 1, 0, 0);          // R6 wide flag write
    op(1, 0, 9, 0, 1, 0, 0);          // R6 other offset
    op(0, 0, 0, 0, 0, 1, 1);          // R7 fixed write
    op(1, 0, 0, 0, 0, 1, 1);          // R7 collision, fixed wins
    op(1, 0, 0, 0, 1, 1, 0);          // R7 collision opposite
    op(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 600; i++) begin
      int sel, a;
      sel = $urandom_range(0, 4);
      a = (sel == 0) ? 0 : (sel == 1) ? 4 : (sel == 2) ? 8 : $urandom_range(0, 255);
      op($urandom_range(0, 1), $urandom_range(0, 1), a, ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0,
         ($urandom_range(0, 1)) ? $urandom_range(0, 3) : $urandom_range(0, 255),
         $urandom_range(0, 3) == 0, $urandom_range(0, 255));
    end
    op(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule